// File: doc/BRIEF.md
# Presettable Counter with Terminal-Count Reload

This block is a synchronous binary up counter, eight bits wide by default, that can be loaded in parallel with a preset value. Its terminal-count flag is active low and is asserted while every count bit is one. A mode input chooses between two uses of that flag. In free mode the counter ignores the flag and wraps from all-ones to zero. In reload mode the flag is fed back so that the counter reloads the preset instead of wrapping, which makes it a programmable divider.

Wider counters are built by chaining stages. The terminal-count output of a lower stage drives the count enable of the next stage. A separate true/complement carry pair is a one-clock-delayed copy of the terminal-count condition. It is meant for a single stage used alone and is not to be used in a chain. A master reset clears the count asynchronously. Release of that reset is synchronized to the clock.

Top module: `tc_reload_counter`

## Requirements
- R1: Driving `arst_n_i` low clears `count_o` to zero and `cout_o` to 0 at once, without waiting for a clock edge. Counting resumes only after the release has passed a two-flop synchronizer.
- R2: When `load_n_i` is low, the next rising edge loads `preset_i` into `count_o`. This load wins over counting and happens whatever the levels of `cnt_en_n_i` and `reload_mode_i`.
- R3: When `load_n_i` is high and `cnt_en_n_i` is high, `count_o` holds its value. No automatic reload takes place, even at all-ones in reload mode.
- R4: When `load_n_i` is high and `cnt_en_n_i` is low, each rising edge adds one to `count_o`. In free mode (`reload_mode_i` = 0) the count wraps from 0xFF to 0x00.
- R5: `tc_n_o` is 0 exactly while `count_o` is all ones (0xFF), in the same cycle, and is 1 otherwise.
- R6: With `reload_mode_i` = 1 and counting enabled, the edge at which `count_o` is 0xFF loads `preset_i`. For a preset P, `tc_n_o` is low once every 256 − P clocks.
- R7: `cout_o` is 1 in the cycle after a cycle in which `count_o` was 0xFF, and is 0 otherwise. `cout_n_o` is always the complement of `cout_o`.
- R8: When `tc_n_o` of one stage feeds `cnt_en_n_i` of a second stage that shares its clock, the second stage advances by one each time the first stage wraps through 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counting clock, rising edge |
| arst_n_i | input | 1 | Asynchronous master reset, active low |
| load_n_i | input | 1 | Parallel load request, active low |
| preset_i | input | W (8) | Value used for parallel load and for automatic reload |
| cnt_en_n_i | input | 1 | Count enable, active low; takes the lower stage's `tc_n_o` in a chain |
| reload_mode_i | input | 1 | 1 = reload preset at terminal count, 0 = free running; tie low when not used |
| count_o | output | W (8) | Current count |
| tc_n_o | output | 1 | Terminal count, active low, cascade output |
| cout_o | output | 1 | Registered carry, true phase, for a stage used alone |
| cout_n_o | output | 1 | Registered carry, complement phase |

## Verification
A load, an increment or an automatic reload shows on `count_o` one rising edge after the inputs that cause it. `tc_n_o` follows `count_o` in the same cycle, and the carry pair follows `tc_n_o` one edge later. The bench changes inputs on falling edges and samples on the next falling edge, so each check sees exactly one register update. Reset is the exception: assertion is checked a nanosecond after `arst_n_i` falls, between edges. After release the bench waits three edges before expecting counting, to cover the two synchronizer flops. The divider and cascade checks count low cycles of `tc_n_o`, or the steps of the upper stage, over fixed windows of 256 − P or 256 clocks.

// File: rtl/tcr_pkg.sv
`timescale 1ns/1ps
package tcr_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD    = 2'd0,
    ACT_INC     = 2'd1,
    ACT_PRESET  = 2'd2,
    ACT_RELOAD  = 2'd3
  } cnt_act_e;
endpackage

// File: rtl/tcr_rst_sync.sv
`timescale 1ns/1ps
module tcr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/tcr_tc_detect.sv
`timescale 1ns/1ps
module tcr_tc_detect #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] count_i,
  output logic         all_ones_o
);
  logic [W:0] chain;

  assign chain[0] = 1'b1;
  for (genvar b = 0; b < W; b++) begin : g_and
    assign chain[b+1] = chain[b] & count_i[b];
  end

  assign all_ones_o = chain[W];
endmodule

// File: rtl/tcr_next_state.sv
`timescale 1ns/1ps
module tcr_next_state
  import tcr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         load_n_i,
  input  logic         cnt_en_n_i,
  input  logic         reload_mode_i,
  input  logic         all_ones_i,
  input  logic [W-1:0] count_i,
  input  logic [W-1:0] preset_i,
  output cnt_act_e     act_o,
  output logic [W-1:0] count_nxt_o
);
  localparam logic [W-1:0] STEP = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    act_o = ACT_HOLD;
    if (!load_n_i) begin
      act_o = ACT_PRESET;
    end else if (!cnt_en_n_i) begin
      if (reload_mode_i && all_ones_i) act_o = ACT_RELOAD;
      else                             act_o = ACT_INC;
    end
  end

  always_comb begin
    unique case (act_o)
      ACT_PRESET, ACT_RELOAD: count_nxt_o = preset_i;
      ACT_INC:                count_nxt_o = count_i + STEP;
      default:                count_nxt_o = count_i;
    endcase
  end
endmodule

// File: rtl/tc_reload_counter.sv
`timescale 1ns/1ps
module tc_reload_counter
  import tcr_pkg::*;
#(
  parameter int unsigned W           = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         arst_n_i,
  input  logic         load_n_i,
  input  logic [W-1:0] preset_i,
  input  logic         cnt_en_n_i,
  input  logic         reload_mode_i,
  output logic [W-1:0] count_o,
  output logic         tc_n_o,
  output logic         cout_o,
  output logic         cout_n_o
);
  logic         rst_n;
  logic         all_ones;
  cnt_act_e     act;
  logic [W-1:0] count_q;
  logic [W-1:0] count_nxt;
  logic         count_ce;
  logic         cout_q;

  tcr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i    (clk_i),
    .arst_n_i (arst_n_i),
    .rst_n_o  (rst_n)
  );

  tcr_tc_detect #(.W(W)) u_tc_detect (
    .count_i    (count_q),
    .all_ones_o (all_ones)
  );

  tcr_next_state #(.W(W)) u_next_state (
    .load_n_i      (load_n_i),
    .cnt_en_n_i    (cnt_en_n_i),
    .reload_mode_i (reload_mode_i),
    .all_ones_i    (all_ones),
    .count_i       (count_q),
    .preset_i      (preset_i),
    .act_o         (act),
    .count_nxt_o   (count_nxt)
  );

  assign count_ce = (act != ACT_HOLD);

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_ce) count_q <= count_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) cout_q <= 1'b0;
    else        cout_q <= all_ones;
  end

  assign count_o  = count_q;
  assign tc_n_o   = ~all_ones;
  assign cout_o   = cout_q;
  assign cout_n_o = ~cout_q;
endmodule

// File: rtl/tcr_checker.sv
`timescale 1ns/1ps
module tcr_checker #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_n_i,
  input logic         load_n_i,
  input logic [W-1:0] preset_i,
  input logic         cnt_en_n_i,
  input logic         reload_mode_i,
  input logic [W-1:0] count_o,
  input logic         tc_n_o,
  input logic         cout_o,
  input logic         cout_n_o
);
  localparam logic [W-1:0] ALL1 = {W{1'b1}};
  localparam logic [W-1:0] STEP = {{(W-1){1'b0}}, 1'b1};

  // R2
  load_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !load_n_i |=> count_o == $past(preset_i));

  // R3
  hold_count_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (load_n_i && cnt_en_n_i) |=> $stable(count_o));

  // R4
  step_up_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (load_n_i && !cnt_en_n_i && !(reload_mode_i && count_o == ALL1))
      |=> count_o == $past(count_o) + STEP);

  // R5
  tc_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (count_o == ALL1) |-> !tc_n_o);

  // R6
  auto_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (load_n_i && !cnt_en_n_i && reload_mode_i && !tc_n_o)
      |=> count_o == $past(preset_i));

  // R7
  carry_set_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !tc_n_o |=> cout_o);

  // R7
  carry_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    tc_n_o |=> !cout_o);

  // R7
  carry_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    cout_n_o != cout_o);
endmodule

bind tc_reload_counter tcr_checker #(.W(W)) u_tcr_checker (
  .clk_i         (clk_i),
  .rst_n_i       (rst_n),
  .load_n_i      (load_n_i),
  .preset_i      (preset_i),
  .cnt_en_n_i    (cnt_en_n_i),
  .reload_mode_i (reload_mode_i),
  .count_o       (count_o),
  .tc_n_o        (tc_n_o),
  .cout_o        (cout_o),
  .cout_n_o      (cout_n_o)
);

// File: tb/tb_tc_reload_counter.sv
`timescale 1ns/1ps
module tb_tc_reload_counter;
  logic       clk = 1'b0;
  logic       arst_n;
  logic       load_n;
  logic [7:0] preset;
  logic       cnt_en_n;
  logic       reload;
  logic [7:0] count;
  logic       tc_n;
  logic       cout;
  logic       cout_n;
  logic [7:0] hi_count;
  logic       hi_tc_n;
  logic       hi_cout;
  logic       hi_cout_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  tc_reload_counter dut (
    .clk_i(clk), .arst_n_i(arst_n), .load_n_i(load_n), .preset_i(preset),
    .cnt_en_n_i(cnt_en_n), .reload_mode_i(reload), .count_o(count),
    .tc_n_o(tc_n), .cout_o(cout), .cout_n_o(cout_n)
  );

  tc_reload_counter dut_hi (
    .clk_i(clk), .arst_n_i(arst_n), .load_n_i(load_n), .preset_i(preset),
    .cnt_en_n_i(tc_n), .reload_mode_i(1'b0), .count_o(hi_count),
    .tc_n_o(hi_tc_n), .cout_o(hi_cout), .cout_n_o(hi_cout_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  task automatic release_reset();
    cnt_en_n = 1'b1;
    load_n   = 1'b1;
    arst_n   = 1'b1;
    tick(3);
  endtask

  task automatic t_reset();
    arst_n = 1'b0; load_n = 1'b1; cnt_en_n = 1'b1; reload = 1'b0; preset = 8'h00;
    tick(2);
    chk("R1 count in reset", count, 8'h00);
    chk("R1 cout in reset", cout, 0);
    chk("R7 cout_n in reset", cout_n, 1);
    chk("R5 tc_n in reset", tc_n, 1);
    release_reset();
    chk("R1 count after release", count, 8'h00);
  endtask

  task automatic t_load();
    cnt_en_n = 1'b1; load_n = 1'b0; preset = 8'h5A;
    tick(1);
    chk("R2 load with enable off", count, 8'h5A);
    cnt_en_n = 1'b0; reload = 1'b1; preset = 8'hC3;
    tick(1);
    chk("R2 load over counting", count, 8'hC3);
    load_n = 1'b1; cnt_en_n = 1'b1; reload = 1'b0;
  endtask

  task automatic t_hold();
    preset = 8'h11;
    tick(5);
    chk("R3 hold", count, 8'hC3);
    chk("R5 tc_n idle", tc_n, 1);
  endtask

  task automatic t_free();
    reload = 1'b0; preset = 8'hFD; load_n = 1'b0;
    tick(1);
    load_n = 1'b1; cnt_en_n = 1'b0;
    tick(1);
    chk("R4 increment", count, 8'hFE);
    chk("R5 tc_n before all-ones", tc_n, 1);
    tick(1);
    chk("R4 reach FF", count, 8'hFF);
    chk("R5 tc_n at all-ones", tc_n, 0);
    chk("R7 cout not yet", cout, 0);
    tick(1);
    chk("R4 wrap to zero", count, 8'h00);
    chk("R7 cout one clock later", cout, 1);
    chk("R7 cout_n complement", cout_n, 0);
    chk("R5 tc_n released", tc_n, 1);
    tick(1);
    chk("R7 cout single cycle", cout, 0);
    chk("R4 after wrap", count, 8'h01);
    cnt_en_n = 1'b1;
  endtask

  task automatic t_reload(input logic [7:0] p);
    int   lows = 0;
    logic [7:0] exp;
    reload = 1'b1; preset = p; load_n = 1'b0;
    tick(1);
    load_n = 1'b1; cnt_en_n = 1'b0;
    exp = p;
    for (int i = 0; i < 3 * (256 - int'(p)); i++) begin
      if (tc_n == 1'b0) lows++;
      exp = (exp == 8'hFF) ? p : exp + 8'h01;
      tick(1);
      if (count != exp) chk("R6 reload sequence", count, exp);
    end
    checks++;
    chk("R6 tc pulses per three periods", lows, 3);
    cnt_en_n = 1'b1;
  endtask

  task automatic t_hold_at_tc();
    // count is FF after t_reload(FF); reload mode on, enable off
    preset = 8'h10;
    tick(3);
    chk("R3 no reload while disabled", count, 8'hFF);
    chk("R5 tc_n held low", tc_n, 0);
  endtask

  task automatic t_async();
    reload = 1'b0; preset = 8'h33; load_n = 1'b0;
    tick(1);
    load_n = 1'b1;
    chk("R2 preload", count, 8'h33);
    #2 arst_n = 1'b0;
    #1 chk("R1 immediate clear", count, 8'h00);
    cnt_en_n = 1'b0;
    tick(2);
    chk("R1 held while asserted", count, 8'h00);
    release_reset();
    chk("R1 idle after release", count, 8'h00);
  endtask

  task automatic t_cascade();
    reload = 1'b0; preset = 8'h00; load_n = 1'b0; cnt_en_n = 1'b1;
    tick(1);
    load_n = 1'b1; cnt_en_n = 1'b0;
    tick(255);
    chk("R8 low stage at FF", count, 8'hFF);
    chk("R8 high stage still 0", hi_count, 8'h00);
    tick(1);
    chk("R8 high stage step 1", hi_count, 8'h01);
    chk("R8 low stage wrapped", count, 8'h00);
    tick(256);
    chk("R8 high stage step 2", hi_count, 8'h02);
    cnt_en_n = 1'b1;
  endtask

  initial begin
    t_reset();
    t_load();
    t_hold();
    t_free();
    t_reload(8'hF0);
    t_reload(8'hFE);
    t_reload(8'hFF);
    t_hold_at_tc();
    t_async();
    t_cascade();
    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      report();
      $finish;
    end
  end
endmodule